// File: doc/BRIEF.md
# Power-Up Memory Restore Sequencer

This block brings working RAM into a usable state after power is applied, before the ladder scan engine is allowed to run. A battery status input chooses between two restore modes. With a failed battery, or on the first power-up, the block performs a full (cold) restore. It copies the user program, the register data area and the jump table from the nonvolatile store into RAM, and then fills the output status table with zeros. With a healthy battery it performs a partial (hot) restore and copies only the user program. The battery-backed registers, jump table and output states therefore survive, and timers, counters and held outputs continue from their values before the outage.

The store is read through a synchronous port whose data returns one cycle after the read strobe. RAM is written through a single synchronous write port. Each copied word takes a read cycle followed by a write cycle. Each cleared word takes one write cycle. The store is assumed to hold every region at the same word address that the region occupies in RAM. The scan engine is held in reset until the block signals completion.

Top module: `mem_restore_seq`

## Requirements
- R1: The battery input is sampled in the first clock cycle after reset is released. Low selects a cold restore and high selects a hot restore.
- R2: In both modes, every RAM word from address 0 to PROG_LEN-1 is written with the store word read at the same address.
- R3: A cold restore copies the store words at addresses 4096 through 4351 into the same RAM addresses.
- R4: A cold restore copies the store words at addresses 8192 through 8447 into the same RAM addresses.
- R5: A cold restore writes zero to every RAM word from OUT_BASE to OUT_BASE+OUT_LEN-1.
- R6: A hot restore writes no RAM address outside the program area.
- R7: Writes occur in the order program area, register area, jump table, output table, each area in ascending address order. Areas that the mode does not cover are skipped.
- R8: Each copied word is read in one cycle and written to the same address in the next cycle. A read and a write never share a cycle.
- R9: `restore_done` is high for exactly one cycle, in the cycle after the last RAM write, and is not raised again until the next reset.
- R10: `scan_hold` is high from reset until `restore_done` rises, and it stays low from then until the next reset.
- R11: A change of the battery input after it has been sampled has no effect on the restore under way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| batt_ok | input | 1 | Battery retention good (1) or failed (0) |
| rom_rd_en | output | 1 | Store read strobe |
| rom_addr | output | ADDR_W | Store word address |
| rom_rd_data | input | DATA_W | Store data, valid one cycle after the strobe |
| ram_wr_en | output | 1 | RAM write strobe |
| ram_addr | output | ADDR_W | RAM word address |
| ram_wr_data | output | DATA_W | RAM write data |
| restore_done | output | 1 | One-cycle completion pulse |
| scan_hold | output | 1 | Holds the scan engine in reset while high |

## Verification
The bench builds the block with a 12-word program area and a 16-word output table at address 1024. The register and jump areas keep their default fixed addresses. These small areas keep a full cold restore near a thousand cycles, so one run covers every area boundary, the read-to-write pairing at each area change, and the switch from copying to clearing. A cold run and a hot run each follow a reset, and in both the battery input is flipped part way through. This exercises the mode latch and the skipping of areas, and any stray write outside the program area during a hot restore is reported.

// File: rtl/restore_pkg.sv
package restore_pkg;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_PROG,
      PH_REGS,
      PH_JUMP,
      PH_CLEAR,
      PH_FIN,
      PH_DONE
   } phase_e;

   function automatic int unsigned max_of3(int unsigned a, int unsigned b, int unsigned c);
      int unsigned m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/rs_phase_ctrl.sv
module rs_phase_ctrl
   import restore_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   batt_ok_i,
   input  logic   region_last_i,
   output phase_e phase_o,
   output logic   cold_o
);

   phase_e phase_q, phase_nxt;
   logic   cold_q;

   always_comb begin
      case (phase_q)
         PH_PROG:  phase_nxt = cold_q ? PH_REGS : PH_FIN;
         PH_REGS:  phase_nxt = PH_JUMP;
         PH_JUMP:  phase_nxt = PH_CLEAR;
         PH_CLEAR: phase_nxt = PH_FIN;
         default:  phase_nxt = phase_q;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         cold_q  <= 1'b0;
      end else begin
         case (phase_q)
            PH_IDLE: begin
               cold_q  <= ~batt_ok_i;
               phase_q <= PH_PROG;
            end
            PH_FIN:  phase_q <= PH_DONE;
            PH_DONE: phase_q <= PH_DONE;
            default: if (region_last_i) phase_q <= phase_nxt;
         endcase
      end
   end

   assign phase_o = phase_q;
   assign cold_o  = cold_q;

   // R11
   mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q != PH_IDLE) |=> $stable(cold_q));

   // R7
   jump_after_regs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_JUMP && $past(phase_q) != PH_JUMP) |-> $past(phase_q) == PH_REGS);

   // R7
   clear_after_jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_CLEAR && $past(phase_q) != PH_CLEAR) |-> $past(phase_q) == PH_JUMP);

endmodule

// File: rtl/rs_word_engine.sv
module rs_word_engine
   import restore_pkg::*;
#(
   parameter int unsigned ADDR_W    = 14,
   parameter int unsigned PROG_BASE = 0,
   parameter int unsigned PROG_LEN  = 64,
   parameter int unsigned REG_BASE  = 4096,
   parameter int unsigned REG_LEN   = 256,
   parameter int unsigned JMP_BASE  = 8192,
   parameter int unsigned JMP_LEN   = 256,
   parameter int unsigned OUT_BASE  = 1024,
   parameter int unsigned OUT_LEN   = 32
)(
   input  logic              clk,
   input  logic              rst_n,
   input  phase_e            phase_i,
   output logic              rd_en_o,
   output logic [ADDR_W-1:0] rd_addr_o,
   output logic              wr_en_o,
   output logic [ADDR_W-1:0] wr_addr_o,
   output logic              last_o
);

   localparam int unsigned MAX_LEN = max_of3(max_of3(PROG_LEN, REG_LEN, JMP_LEN), OUT_LEN, 2);
   localparam int unsigned CNT_W   = $clog2(MAX_LEN + 1);

   logic [CNT_W-1:0]  idx_q, len_m1;
   logic [ADDR_W-1:0] base, addr;
   logic              step_q, copy_ph, clr_ph, last;

   always_comb begin
      base   = '0;
      len_m1 = '0;
      case (phase_i)
         PH_PROG:  begin base = ADDR_W'(PROG_BASE); len_m1 = CNT_W'(PROG_LEN - 1); end
         PH_REGS:  begin base = ADDR_W'(REG_BASE);  len_m1 = CNT_W'(REG_LEN - 1);  end
         PH_JUMP:  begin base = ADDR_W'(JMP_BASE);  len_m1 = CNT_W'(JMP_LEN - 1);  end
         PH_CLEAR: begin base = ADDR_W'(OUT_BASE);  len_m1 = CNT_W'(OUT_LEN - 1);  end
         default:  ;
      endcase
   end

   assign copy_ph = (phase_i == PH_PROG) || (phase_i == PH_REGS) || (phase_i == PH_JUMP);
   assign clr_ph  = (phase_i == PH_CLEAR);
   assign last    = ((copy_ph && step_q) || clr_ph) && (idx_q == len_m1);
   assign addr    = base + ADDR_W'(idx_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx_q  <= '0;
         step_q <= 1'b0;
      end else if (copy_ph) begin
         step_q <= ~step_q;
         if (step_q) idx_q <= last ? '0 : idx_q + 1'b1;
      end else if (clr_ph) begin
         idx_q <= last ? '0 : idx_q + 1'b1;
      end
   end

   assign rd_en_o   = copy_ph && !step_q;
   assign wr_en_o   = (copy_ph && step_q) || clr_ph;
   assign rd_addr_o = addr;
   assign wr_addr_o = addr;
   assign last_o    = last;

   // R8
   rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_en_o && wr_en_o));

   // R8
   wr_follows_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_o && copy_ph) |-> ($past(rd_en_o) && wr_addr_o == $past(rd_addr_o)));

endmodule

// File: rtl/mem_restore_seq.sv
module mem_restore_seq
   import restore_pkg::*;
#(
   parameter int unsigned ADDR_W    = 14,
   parameter int unsigned DATA_W    = 16,
   parameter int unsigned PROG_BASE = 0,
   parameter int unsigned PROG_LEN  = 64,
   parameter int unsigned REG_BASE  = 4096,
   parameter int unsigned REG_LEN   = 256,
   parameter int unsigned JMP_BASE  = 8192,
   parameter int unsigned JMP_LEN   = 256,
   parameter int unsigned OUT_BASE  = 1024,
   parameter int unsigned OUT_LEN   = 32
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              batt_ok,
   output logic              rom_rd_en,
   output logic [ADDR_W-1:0] rom_addr,
   input  logic [DATA_W-1:0] rom_rd_data,
   output logic              ram_wr_en,
   output logic [ADDR_W-1:0] ram_addr,
   output logic [DATA_W-1:0] ram_wr_data,
   output logic              restore_done,
   output logic              scan_hold
);

   localparam int unsigned PROG_END = PROG_BASE + PROG_LEN;

   generate
      if (PROG_LEN < 1 || REG_LEN < 1 || JMP_LEN < 1 || OUT_LEN < 1) begin : g_len_bad
         $error("every restore area needs at least one word");
      end
      if (PROG_END > (1 << ADDR_W) || REG_BASE + REG_LEN > (1 << ADDR_W) ||
          JMP_BASE + JMP_LEN > (1 << ADDR_W) || OUT_BASE + OUT_LEN > (1 << ADDR_W)) begin : g_addr_bad
         $error("restore area exceeds the address space");
      end
      if (DATA_W < 1) begin : g_data_bad
         $error("data width must be positive");
      end
   endgenerate

   phase_e phase;
   logic   cold, region_last;

   rs_phase_ctrl u_ctrl (
      .clk           (clk),
      .rst_n         (rst_n),
      .batt_ok_i     (batt_ok),
      .region_last_i (region_last),
      .phase_o       (phase),
      .cold_o        (cold)
   );

   rs_word_engine #(
      .ADDR_W    (ADDR_W),
      .PROG_BASE (PROG_BASE), .PROG_LEN (PROG_LEN),
      .REG_BASE  (REG_BASE),  .REG_LEN  (REG_LEN),
      .JMP_BASE  (JMP_BASE),  .JMP_LEN  (JMP_LEN),
      .OUT_BASE  (OUT_BASE),  .OUT_LEN  (OUT_LEN)
   ) u_eng (
      .clk       (clk),
      .rst_n     (rst_n),
      .phase_i   (phase),
      .rd_en_o   (rom_rd_en),
      .rd_addr_o (rom_addr),
      .wr_en_o   (ram_wr_en),
      .wr_addr_o (ram_addr),
      .last_o    (region_last)
   );

   assign ram_wr_data  = (phase == PH_CLEAR) ? '0 : rom_rd_data;
   assign restore_done = (phase == PH_FIN);
   assign scan_hold    = (phase != PH_FIN) && (phase != PH_DONE);

   // R6
   hot_scope_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ram_wr_en && !cold) |-> (ram_addr >= ADDR_W'(PROG_BASE) && 32'(ram_addr) < PROG_END));

   // R9
   done_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
      restore_done |=> !restore_done);

   // R9
   done_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(restore_done) |-> $past(ram_wr_en));

   // R10
   hold_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(scan_hold) |-> restore_done);

   // R10
   hold_stays_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !scan_hold |=> !scan_hold);

endmodule

// File: tb/sim_mem_restore_seq.sv
module sim_mem_restore_seq;

   localparam int ADDR_W   = 14;
   localparam int DATA_W   = 16;
   localparam int PROG_LEN = 12;
   localparam int OUT_BASE = 1024;
   localparam int OUT_LEN  = 16;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              batt_ok = 1'b0;
   logic              rom_rd_en, ram_wr_en, restore_done, scan_hold;
   logic [ADDR_W-1:0] rom_addr, ram_addr;
   logic [DATA_W-1:0] rom_q = '0;
   logic [DATA_W-1:0] ram_wr_data;

   int checks = 0;
   int errors = 0;
   int done_cnt = 0;
   int cycles = 0;
   logic              prev_rd = 1'b0;
   logic [ADDR_W-1:0] prev_rd_addr = '0;

   typedef struct packed {
      logic [ADDR_W-1:0] a;
      logic [DATA_W-1:0] d;
   } wr_item_t;
   wr_item_t exp_q[$];

   always #4 clk = ~clk;

   mem_restore_seq #(
      .ADDR_W (ADDR_W), .DATA_W (DATA_W), .PROG_LEN (PROG_LEN),
      .OUT_BASE (OUT_BASE), .OUT_LEN (OUT_LEN)
   ) u0 (
      .clk (clk), .rst_n (rst_n), .batt_ok (batt_ok),
      .rom_rd_en (rom_rd_en), .rom_addr (rom_addr), .rom_rd_data (rom_q),
      .ram_wr_en (ram_wr_en), .ram_addr (ram_addr), .ram_wr_data (ram_wr_data),
      .restore_done (restore_done), .scan_hold (scan_hold)
   );

   function automatic logic [DATA_W-1:0] pattern(input logic [ADDR_W-1:0] a);
      return {a[7:0] ^ 8'h5A, 2'b10, a[13:8]};
   endfunction

   function automatic string area_tag(input logic [ADDR_W-1:0] a);
      if (a < PROG_LEN) return "R2";
      if (a >= 4096 && a <= 4351) return "R3";
      if (a >= 8192 && a <= 8447) return "R4";
      if (a >= OUT_BASE && a < OUT_BASE + OUT_LEN) return "R5";
      return "R6";
   endfunction

   always @(posedge clk) if (rom_rd_en) rom_q <= pattern(rom_addr);

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // driver: pushes the expected write sequence for one restore
   task automatic push_expect(input bit cold);
      exp_q.delete();
      for (int i = 0; i < PROG_LEN; i++) exp_q.push_back({ADDR_W'(i), pattern(ADDR_W'(i))});
      if (cold) begin
         for (int i = 4096; i <= 4351; i++) exp_q.push_back({ADDR_W'(i), pattern(ADDR_W'(i))});
         for (int i = 8192; i <= 8447; i++) exp_q.push_back({ADDR_W'(i), pattern(ADDR_W'(i))});
         for (int i = 0; i < OUT_LEN; i++) exp_q.push_back({ADDR_W'(OUT_BASE + i), {DATA_W{1'b0}}});
      end
   endtask

   // monitor: pops and compares against the design's activity
   always @(negedge clk) begin
      if (rst_n) begin
         if (rom_rd_en && ram_wr_en) check(0, "R8", "read and write in one cycle", 1, 0);
         if (ram_wr_en) begin
            if (exp_q.size() == 0) begin
               check(0, "R6", "unexpected write addr", ram_addr, 0);
            end else begin
               wr_item_t e;
               e = exp_q.pop_front();
               check(ram_addr == e.a, "R7", "write address", ram_addr, e.a);
               check(ram_wr_data == e.d, area_tag(e.a), "write data", ram_wr_data, e.d);
               if (area_tag(e.a) != "R5")
                  check(prev_rd && prev_rd_addr == ram_addr, "R8", "read before write addr",
                        prev_rd_addr, ram_addr);
            end
         end
         if (restore_done) begin
            done_cnt++;
            check(exp_q.size() == 0, "R9", "writes left at done", exp_q.size(), 0);
            check(prev_rd == 1'b0 && !ram_wr_en, "R9", "bus quiet at done", ram_wr_en, 0);
         end
         check(scan_hold == (done_cnt == 0), "R10", "scan_hold", scan_hold, done_cnt == 0);
         prev_rd      <= rom_rd_en;
         prev_rd_addr <= rom_addr;
      end else begin
         prev_rd <= 1'b0;
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual %0d cycles expected below 20000", cycles);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   task automatic run_restore(input bit batt, input int flip_at);
      @(posedge clk); #1;
      rst_n = 1'b0;
      batt_ok = batt;
      done_cnt = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check(scan_hold == 1'b1, "R10", "scan_hold in reset", scan_hold, 1);
      check(!restore_done && !ram_wr_en && !rom_rd_en, "R9", "idle in reset",
            {restore_done, ram_wr_en, rom_rd_en}, 0);
      // R1: mode from batt_ok at first cycle after release
      push_expect(!batt);
      @(posedge clk); #1;
      rst_n = 1'b1;
      repeat (flip_at) @(posedge clk);
      #1 batt_ok = ~batt;   // R11: late change must not matter
      while (done_cnt == 0) @(posedge clk);
      repeat (20) @(posedge clk);
      @(negedge clk);
      check(done_cnt == 1, "R9", "done pulse count", done_cnt, 1);
      check(exp_q.size() == 0, "R1", "expected writes remaining", exp_q.size(), 0);
      check(!scan_hold && !ram_wr_en, "R10", "released and quiet", {scan_hold, ram_wr_en}, 0);
   endtask

   initial begin
      run_restore(1'b0, 40);   // cold: R3 R4 R5, flip to good mid-run (R11)
      run_restore(1'b1, 6);    // hot: R2 R6, flip to failed mid-run (R11)
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule